// File: doc/BRIEF.md
# Board control register file

This block is the register file of a development board's system controller. A processor reaches it over a simple 32-bit bus with separate read and write strobes. Only the low 20 address bits are decoded, so the block appears at every alias of its window. It holds these registers:

- a bank of fixed readback words (switches, jumpers, build status);
- an 8-LED bar;
- an eight-character ASCII display buffer, which is driven out to a renderer as a flat character array;
- a magic-value soft-reset trigger;
- a break/reset byte and a general-purpose output byte;
- the bit-banged I2C control registers. These drive clock and data toward an external serial EEPROM and read its data line back.

The display can be loaded in two ways. A single word write shows the value as eight uppercase hex digits. Alternatively, each character can be written on its own. The general-purpose input word loops back the I2C output register while the I2C select bit is set.

Top module: `brd_ctrl_top`

## Requirements
- R1: Only address bits [19:0] are decoded, so upper address bits have no effect. Any offset not listed as readable (including 0x410, 0x418–0x450 and 0x500) reads as zero, and writes to unlisted offsets change no output or register.
- R2: Read data is registered. It appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`, and it holds its value until the next read. A read and a write to the same register in the same cycle return the old value.
- R3: The switch word (0x200) and the jumper word (0x210) always read zero. Writes to them are ignored.
- R4: The status word (0x208) reads 0x12 when `BIG_ENDIAN` is 1 and 0x10 when it is 0.
- R5: The LED register (0x408) stores the low 8 bits of a write, reads back that value, drives `led_bar`, and resets to 0x00.
- R6: The break register (0x508, reset 0x0A) drives `brk_out`, and the general-purpose output register (0xA00, reset 0x00) drives `gp_out`. Each stores the low 8 bits of a write and reads back.
- R7: A write to 0x410 sets all eight characters to the uppercase ASCII hex digits of the 32-bit value ('0'–'9' = 0x30–0x39, 'A'–'F' = 0x41–0x46). The most significant nibble goes to character 0. Character k occupies `disp_chars[8k+7:8k]`.
- R8: A write to offset 0x418 + 8k (k = 0..7) sets character k to the low byte of the data and leaves the other characters unchanged. Offsets in that range that are not multiples of 8 are ignored.
- R9: After reset every display character is an ASCII space (0x20).
- R10: A write of exactly 0x00000042 to 0x500 raises `sys_rst_req` for exactly one cycle, in the cycle after the write edge. A write of any other value to 0x500 leaves it low.
- R11: The I2C output-enable register (0xB08) keeps 2 bits and resets to 0. The I2C output register (0xB10) keeps 32 bits and resets to 3; its bit 1 drives `i2c_scl_out` and its bit 0 drives `i2c_sda_out`. The I2C select register (0xB18) keeps 1 bit and resets to 1. All three read back.
- R12: The general-purpose input word (0xA08) returns the I2C output register when select is 1, and zero when select is 0. The I2C input word (0xB00) returns 0x2 with bit 0 replaced by `eeprom_sda_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Byte address; bits [19:0] decoded |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eeprom_sda_in | input | 1 | Data line returned from the serial EEPROM |
| led_bar | output | 8 | LED bar state |
| brk_out | output | 8 | Break/reset register |
| gp_out | output | 8 | General-purpose output register |
| disp_chars | output | 64 | Display characters, character k at [8k+7:8k] |
| sys_rst_req | output | 1 | One-cycle system reset request |
| i2c_oe | output | 2 | I2C output enables |
| i2c_scl_out | output | 1 | I2C clock drive |
| i2c_sda_out | output | 1 | I2C data drive |

## Verification
The bench writes to the soft-reset word with 0x42, with 0x43 and with 0x142. A decoder that compared only the low byte would fire on 0x142. A design that held the request as a level would still show it a cycle later.

Two word writes together cover every hex digit class. A nibble-order or letter-case error would reverse the display or give lowercase digits. A per-character write at a misaligned offset (0x434) must leave the buffer untouched; a decoder that ignores the low address bits would overwrite character 3.

The bench also checks these cases:
- Loopback on the general-purpose input word is checked with select both set and cleared.
- An address with nonzero bits above bit 19 must still reach the LED register.
- The display and soft-reset offsets must read zero, so read paths that leak write-only state are caught.

// File: rtl/brd_pkg.sv
// Package: offsets and helpers shared by the board control register file.
// Assumes byte offsets within a 20-bit decoded window.
package brd_pkg;

    localparam int OFF_W = 20;

    localparam logic [OFF_W-1:0] OFF_SWITCH   = 20'h00200;
    localparam logic [OFF_W-1:0] OFF_STATUS   = 20'h00208;
    localparam logic [OFF_W-1:0] OFF_JUMPER   = 20'h00210;
    localparam logic [OFF_W-1:0] OFF_LED      = 20'h00408;
    localparam logic [OFF_W-1:0] OFF_HEXWORD  = 20'h00410;
    localparam logic [OFF_W-1:0] OFF_CHAR0    = 20'h00418;
    localparam logic [OFF_W-1:0] OFF_SOFTRST  = 20'h00500;
    localparam logic [OFF_W-1:0] OFF_BRK      = 20'h00508;
    localparam logic [OFF_W-1:0] OFF_GPOUT    = 20'h00A00;
    localparam logic [OFF_W-1:0] OFF_GPIN     = 20'h00A08;
    localparam logic [OFF_W-1:0] OFF_I2C_IN   = 20'h00B00;
    localparam logic [OFF_W-1:0] OFF_I2C_OE   = 20'h00B08;
    localparam logic [OFF_W-1:0] OFF_I2C_OUT  = 20'h00B10;
    localparam logic [OFF_W-1:0] OFF_I2C_SEL  = 20'h00B18;

    localparam logic [31:0] SOFTRST_KEY = 32'h0000_0042;
    localparam logic [7:0]  ASCII_SPACE = 8'h20;

    // Converts one nibble to its uppercase ASCII hex digit.
    function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
        if (nib < 4'd10) nib_to_ascii = 8'h30 + {4'd0, nib};
        else             nib_to_ascii = 8'h37 + {4'd0, nib};
    endfunction

endpackage

// File: rtl/brd_disp_buf.sv
// Display buffer: NCHARS byte-wide characters. A word write fills every
// character with a hex digit (most significant nibble into character 0);
// a character write replaces one character. Assumes the two write
// strobes are mutually exclusive (guaranteed by the address decode).
module brd_disp_buf
    import brd_pkg::*;
#(
    parameter int NCHARS = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NCHARS > 1) ? $clog2(NCHARS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_word,
    input  logic                  wr_char,
    input  logic [IDX_W-1:0]      char_idx,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NCHARS*8-1:0]   chars
);

    for (genvar k = 0; k < NCHARS; k++) begin : g_char
        localparam int NIB_LSB = DATA_W - 4 * (k + 1);
        logic [7:0] ch_q;

        // Holds character k; word load or single-character load.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ch_q <= ASCII_SPACE;
            else if (wr_word)
                ch_q <= nib_to_ascii(wdata[NIB_LSB +: 4]);
            else if (wr_char && (char_idx == IDX_W'(k)))
                ch_q <= wdata[7:0];
        end

        assign chars[8*k +: 8] = ch_q;
    end

endmodule

// File: rtl/brd_i2c_regs.sv
// Bit-banged I2C control registers: output enables, the output word
// (bit 1 = clock, bit 0 = data) and the loopback select bit.
// Assumes one-cycle write strobes from the top-level decode.
module brd_i2c_regs #(
    parameter int DATA_W = 32,
    parameter int OE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_oe,
    input  logic              wr_out,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [OE_W-1:0]   oe,
    output logic [DATA_W-1:0] out_word,
    output logic              sel
);

    // Stores the enables, output word and select bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe       <= '0;
            out_word <= DATA_W'(3);
            sel      <= 1'b1;
        end else begin
            if (wr_oe)  oe       <= wdata[OE_W-1:0];
            if (wr_out) out_word <= wdata;
            if (wr_sel) sel      <= wdata[0];
        end
    end

endmodule

// File: rtl/brd_ctrl_top.sv
// Board control register file. Decodes the low OFF_W address bits of a
// simple read/write bus, stores the byte registers, feeds the display
// buffer and I2C registers, and returns registered read data one cycle
// after a read strobe. Assumes bus_wr and bus_rd are single-cycle strobes.
module brd_ctrl_top
    import brd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NCHARS     = 8,
    parameter int BYTE_W     = 8,
    parameter bit BIG_ENDIAN = 1'b1,
    localparam int IDX_W     = (NCHARS > 1) ? $clog2(NCHARS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 eeprom_sda_in,
    output logic [BYTE_W-1:0]    led_bar,
    output logic [BYTE_W-1:0]    brk_out,
    output logic [BYTE_W-1:0]    gp_out,
    output logic [NCHARS*8-1:0]  disp_chars,
    output logic                 sys_rst_req,
    output logic [1:0]           i2c_oe,
    output logic                 i2c_scl_out,
    output logic                 i2c_sda_out
);

    localparam logic [DATA_W-1:0] STATUS_VAL = BIG_ENDIAN ? DATA_W'(8'h12) : DATA_W'(8'h10);
    localparam logic [DATA_W-1:0] I2C_IN_RST = DATA_W'(3);
    localparam logic [OFF_W-1:0]  CHAR_LAST  = OFF_CHAR0 + OFF_W'(8 * (NCHARS - 1));

    logic [OFF_W-1:0] off;
    logic             unused_addr_hi;
    logic [OFF_W-1:0] char_rel;
    logic             char_hit;
    logic [DATA_W-1:0] i2c_word;
    logic             i2c_sel;
    logic [DATA_W-1:0] rd_next;

    assign off            = bus_addr[OFF_W-1:0];
    assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFF_W];
    assign char_rel       = off - OFF_CHAR0;
    assign char_hit       = (off >= OFF_CHAR0) && (off <= CHAR_LAST) && (off[2:0] == 3'd0);

    // Byte registers: LED bar, break and general-purpose output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_bar <= '0;
            brk_out <= BYTE_W'(8'h0A);
            gp_out  <= '0;
        end else if (bus_wr) begin
            if (off == OFF_LED)   led_bar <= bus_wdata[BYTE_W-1:0];
            if (off == OFF_BRK)   brk_out <= bus_wdata[BYTE_W-1:0];
            if (off == OFF_GPOUT) gp_out  <= bus_wdata[BYTE_W-1:0];
        end
    end

    // One-cycle reset request on the magic value only.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_rst_req <= 1'b0;
        else        sys_rst_req <= bus_wr && (off == OFF_SOFTRST) && (bus_wdata == SOFTRST_KEY);
    end

    brd_disp_buf #(
        .NCHARS (NCHARS),
        .DATA_W (DATA_W)
    ) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_word  (bus_wr && (off == OFF_HEXWORD)),
        .wr_char  (bus_wr && char_hit),
        .char_idx (char_rel[3 +: IDX_W]),
        .wdata    (bus_wdata),
        .chars    (disp_chars)
    );

    brd_i2c_regs #(
        .DATA_W (DATA_W),
        .OE_W   (2)
    ) u_i2c (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_oe    (bus_wr && (off == OFF_I2C_OE)),
        .wr_out   (bus_wr && (off == OFF_I2C_OUT)),
        .wr_sel   (bus_wr && (off == OFF_I2C_SEL)),
        .wdata    (bus_wdata),
        .oe       (i2c_oe),
        .out_word (i2c_word),
        .sel      (i2c_sel)
    );

    assign i2c_scl_out = i2c_word[1];
    assign i2c_sda_out = i2c_word[0];

    // Read multiplexer over the readable offsets; all others give zero.
    always_comb begin
        rd_next = '0;
        case (off)
            OFF_STATUS:  rd_next = STATUS_VAL;
            OFF_LED:     rd_next = DATA_W'(led_bar);
            OFF_BRK:     rd_next = DATA_W'(brk_out);
            OFF_GPOUT:   rd_next = DATA_W'(gp_out);
            OFF_GPIN:    rd_next = i2c_sel ? i2c_word : '0;
            OFF_I2C_IN:  rd_next = {I2C_IN_RST[DATA_W-1:1], eeprom_sda_in};
            OFF_I2C_OE:  rd_next = DATA_W'(i2c_oe);
            OFF_I2C_OUT: rd_next = i2c_word;
            OFF_I2C_SEL: rd_next = DATA_W'(i2c_sel);
            default:     rd_next = '0;
        endcase
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

endmodule

// File: rtl/brd_ctrl_chk.sv
// Checker for brd_ctrl_top: relates bus writes and reads to the outputs.
// Assumes default widths; attached with the bind below.
module brd_ctrl_chk
    import brd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [7:0]  led_bar,
    input logic        sys_rst_req,
    input logic        i2c_scl_out,
    input logic        i2c_sda_out
);

    logic [OFF_W-1:0] c_off;
    assign c_off = bus_addr[OFF_W-1:0];

    a_r10_magic_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && c_off == OFF_SOFTRST && bus_wdata == 32'h42) |=> sys_rst_req);

    a_r10_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && c_off == OFF_SOFTRST && bus_wdata == 32'h42) |=> !sys_rst_req);

    a_r5_led_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && c_off == OFF_LED) |=> (led_bar == $past(bus_wdata[7:0])));

    a_r5_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && c_off == OFF_LED) |=> $stable(led_bar));

    a_r11_i2c_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && c_off == OFF_I2C_OUT) |=> ($stable(i2c_scl_out) && $stable(i2c_sda_out)));

    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    a_r3_switch_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (c_off == OFF_SWITCH || c_off == OFF_JUMPER)) |=> (bus_rdata == 32'd0));

endmodule

bind brd_ctrl_top brd_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .led_bar     (led_bar),
    .sys_rst_req (sys_rst_req),
    .i2c_scl_out (i2c_scl_out),
    .i2c_sda_out (i2c_sda_out)
);

// File: tb/tb_brd_ctrl_top.sv
// Directed bench for brd_ctrl_top: one task per scenario.
module tb_brd_ctrl_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eeprom_sda_in = 1'b0;
    logic [7:0]  led_bar, brk_out, gp_out;
    logic [63:0] disp_chars;
    logic        sys_rst_req;
    logic [1:0]  i2c_oe;
    logic        i2c_scl_out, i2c_sda_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brd_ctrl_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eeprom_sda_in(eeprom_sda_in), .led_bar(led_bar), .brk_out(brk_out),
        .gp_out(gp_out), .disp_chars(disp_chars), .sys_rst_req(sys_rst_req),
        .i2c_oe(i2c_oe), .i2c_scl_out(i2c_scl_out), .i2c_sda_out(i2c_sda_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write takes effect at the edge inside the task; returns at the next negedge.
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R5 led reset", 64'(led_bar), 64'h00);
        check("R6 brk reset", 64'(brk_out), 64'h0A);
        check("R6 gp reset", 64'(gp_out), 64'h00);
        check("R9 display reset", disp_chars, 64'h2020202020202020);
        check("R11 oe reset", 64'(i2c_oe), 64'h0);
        check("R11 scl/sda reset", 64'({i2c_scl_out, i2c_sda_out}), 64'h3);
        rd(32'h00000B18, d); check("R11 sel reset", 64'(d), 64'h1);
        rd(32'h00000B10, d); check("R11 out reset", 64'(d), 64'h3);
        check("R10 no request after reset", 64'(sys_rst_req), 64'h0);
    endtask

    task automatic t_fixed();
        logic [31:0] d;
        wr(32'h00000200, 32'hFFFFFFFF);
        wr(32'h00000210, 32'hFFFFFFFF);
        rd(32'h00000200, d); check("R3 switch zero", 64'(d), 64'h0);
        rd(32'h00000210, d); check("R3 jumper zero", 64'(d), 64'h0);
        rd(32'h00000208, d); check("R4 status big-endian", 64'(d), 64'h12);
    endtask

    task automatic t_bytes();
        logic [31:0] d;
        wr(32'h00000408, 32'h123456A5);
        check("R5 led drive", 64'(led_bar), 64'hA5);
        rd(32'h00000408, d); check("R5 led readback", 64'(d), 64'hA5);
        wr(32'hFFF00408, 32'h0000003C);
        check("R1 upper address ignored", 64'(led_bar), 64'h3C);
        wr(32'h00000508, 32'hABCD0177);
        rd(32'h00000508, d); check("R6 brk readback", 64'(d), 64'h77);
        check("R6 brk drive", 64'(brk_out), 64'h77);
        wr(32'h00000A00, 32'h000000C3);
        check("R6 gp drive", 64'(gp_out), 64'hC3);
        rd(32'h00000A00, d); check("R6 gp readback", 64'(d), 64'hC3);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(32'h00000300, 32'hFFFFFFFF);
        check("R1 unmapped write leaves led", 64'(led_bar), 64'h3C);
        check("R1 unmapped write leaves display", disp_chars, 64'h2020202020202020);
        rd(32'h00000300, d); check("R1 unmapped read", 64'(d), 64'h0);
        rd(32'h00000410, d); check("R1 display word read zero", 64'(d), 64'h0);
        rd(32'h00000500, d); check("R1 softreset read zero", 64'(d), 64'h0);
    endtask

    task automatic t_display();
        wr(32'h00000410, 32'h1234ABCD);
        check("R7 hex word 1234ABCD", disp_chars, 64'h4443424134333231);
        wr(32'h00000410, 32'hF09E5C70);
        check("R7 hex word F09E5C70", disp_chars, 64'h3037433545393046);
        wr(32'h00000430, 32'h0001FF5A);
        check("R8 char 3 write", disp_chars, 64'h303743355A393046);
        wr(32'h00000434, 32'h00000061);
        check("R8 misaligned ignored", disp_chars, 64'h303743355A393046);
        wr(32'h00000418, 32'h00000062);
        wr(32'h00000450, 32'h00000063);
        check("R8 chars 0 and 7", disp_chars, 64'h633743355A393062);
    endtask

    task automatic t_softreset();
        wr(32'h00000500, 32'h00000042);
        check("R10 pulse high", 64'(sys_rst_req), 64'h1);
        @(negedge clk);
        check("R10 pulse one cycle", 64'(sys_rst_req), 64'h0);
        wr(32'h00000500, 32'h00000043);
        check("R10 other value", 64'(sys_rst_req), 64'h0);
        wr(32'h00000500, 32'h00000142);
        check("R10 full word compare", 64'(sys_rst_req), 64'h0);
    endtask

    task automatic t_i2c();
        logic [31:0] d;
        wr(32'h00000B08, 32'hFFFFFFFF);
        check("R11 oe two bits", 64'(i2c_oe), 64'h3);
        rd(32'h00000B08, d); check("R11 oe readback", 64'(d), 64'h3);
        wr(32'h00000B10, 32'hDEAD0002);
        check("R11 scl=1 sda=0", 64'({i2c_scl_out, i2c_sda_out}), 64'h2);
        rd(32'h00000A08, d); check("R12 gp input loopback", 64'(d), 64'hDEAD0002);
        wr(32'h00000B18, 32'hFFFFFFFE);
        rd(32'h00000B18, d); check("R11 sel one bit", 64'(d), 64'h0);
        rd(32'h00000A08, d); check("R12 gp input zero when unselected", 64'(d), 64'h0);
        eeprom_sda_in = 1'b1;
        rd(32'h00000B00, d); check("R12 i2c input sda=1", 64'(d), 64'h3);
        eeprom_sda_in = 1'b0;
        rd(32'h00000B00, d); check("R12 i2c input sda=0", 64'(d), 64'h2);
    endtask

    task automatic t_rdtiming();
        logic [31:0] d;
        rd(32'h00000508, d);
        @(negedge clk);
        bus_addr = 32'h00000408;
        @(negedge clk);
        check("R2 rdata held without read", 64'(bus_rdata), 64'h77);
        // Same-cycle read and write of the LED register returns the old value.
        bus_wdata = 32'h11; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R2 read returns old value", 64'(bus_rdata), 64'h3C);
        check("R2 write still lands", 64'(led_bar), 64'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_bytes();
        t_unmapped();
        t_display();
        t_softreset();
        t_i2c();
        t_rdtiming();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule